// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block sits next to the parallel port register file and decides whether a host access to the enhanced-mode address or data location may run on the peripheral side. Address cycles move one byte. Data cycles move one, two or four bytes. Wide data goes out, and read results come back, as one byte per peripheral handshake, least significant byte first.

The peripheral answers each byte with either a done pulse or an error pulse. An error stops the transfer and latches a sticky timeout flag. That flag replaces bit 0 of the status byte the host reads. Software clears it by writing the status location with bit 0 set.

Each access is qualified by the control register byte `ctrl_i`. A write needs the handshake-control pattern "init only". A read needs "direction plus init". An access that does not match completes at once without any peripheral activity.

Host accesses are single-cycle `host_req_i` pulses, accepted only while `host_busy_o` is low. Every accepted access ends with a one-cycle `host_done_o` that carries `host_rdata_o`.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset the timeout flag is 0 (`sts_o[0]`=0), `host_busy_o` is 0 and `per_req_o` is 0.
- R2: A write at offset 3 or 4 issues peripheral cycles only when control bits {5,3,2,1,0} equal 0,0,1,0,0 (direction, select, init, autofeed, strobe). Otherwise it completes with no peripheral cycle and no change of the timeout flag.
- R3: A read at offset 3 or 4 issues peripheral cycles only when those bits equal 1,0,1,0,0. A blocked read returns all ones in the access width (0xFF, 0xFFFF or 0xFFFFFFFF) and zeros above it, with no peripheral cycle.
- R4: Offset 3 issues exactly one byte with `per_addr_o`=1, whatever the size code. Offset 4 issues data cycles with `per_addr_o`=0. The size code `host_size_i` gives the data width: 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes.
- R5: Wide writes send `host_wdata_i` bytes from bits [7:0] upward, one byte per peripheral cycle.
- R6: Wide reads place the n-th received byte at bits [8n+7:8n] of `host_rdata_o`.
- R7: A peripheral error on any address or data byte sets the timeout flag. The flag stays set through later successful transfers until cleared.
- R8: A write at offset 1 with bit 0 set clears the timeout flag. A write there with bit 0 clear leaves it unchanged.
- R9: `sts_o` and a read at offset 1 return `sts_pin_i[7:1]` with bit 0 replaced by the timeout flag.
- R10: On an error, no further bytes of that access are requested. Bytes not received read as 0xFF in the result.
- R11: `per_req_o` stays high with stable byte, direction and type until `per_done_i` or `per_err_i`. `host_done_o` is a single-cycle pulse.
- R12: Control bits 7, 6 and 4 have no effect on whether a cycle is allowed.
- R13: Accesses at offsets 0, 2 and 5 to 7 complete with no peripheral cycle, and reads there return all ones in the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Access request pulse, taken when not busy |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_off_i | input | 3 | Register offset |
| host_size_i | input | 2 | Access width code |
| host_wdata_i | input | 32 | Write data |
| host_busy_o | output | 1 | Access in progress |
| host_done_o | output | 1 | Access completed, read data valid |
| host_rdata_o | output | 32 | Read result, masked to the access width |
| ctrl_i | input | 8 | Current control register value |
| sts_pin_i | input | 8 | Raw status byte from the port pins |
| sts_o | output | 8 | Status byte with the timeout flag in bit 0 |
| per_req_o | output | 1 | Peripheral byte cycle request |
| per_we_o | output | 1 | Peripheral cycle direction, 1 = write |
| per_addr_o | output | 1 | 1 = address cycle, 0 = data cycle |
| per_wdata_o | output | 8 | Byte sent to the peripheral |
| per_rdata_i | input | 8 | Byte returned by the peripheral |
| per_done_i | input | 1 | Byte cycle completed |
| per_err_i | input | 1 | Byte cycle failed |

## Verification
The gate is tried with the exact write pattern, the exact read pattern, each pattern used in the wrong direction, a pattern with select added, and patterns with the don't-care bits set. This separates a decode that checks too few bits from one that checks too many. Transfers of one, two and four bytes with distinct byte values reveal any byte-order or count fault in both directions. Errors injected on the first and on a middle byte separate early stopping and 0xFF filling from a run that completes anyway. Status accesses with bit 0 set and clear, against pin values whose own bit 0 differs, show both the sticky behaviour of the flag and the replacement of bit 0.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_DONE} epp_state_e;

  localparam logic [2:0] OFF_STS  = 3'd1;
  localparam logic [2:0] OFF_ADDR = 3'd3;
  localparam logic [2:0] OFF_DATA = 3'd4;

  // control bit positions decoded by the port logic
  localparam int CTL_DIR  = 5;
  localparam int CTL_SEL  = 3;
  localparam int CTL_INIT = 2;
  localparam int CTL_AFD  = 1;
  localparam int CTL_STB  = 0;

  localparam int STS_TMO  = 0;
endpackage

// File: rtl/epp_mode_gate.sv
module epp_mode_gate
  import epp_pkg::*;
#(
  parameter int CTRL_W = 8
) (
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              wr_ok_o,
  output logic              rd_ok_o
);
  logic [4:0] sig;

  assign sig     = {ctrl_i[CTL_DIR], ctrl_i[CTL_SEL], ctrl_i[CTL_INIT],
                    ctrl_i[CTL_AFD], ctrl_i[CTL_STB]};
  assign wr_ok_o = (sig == 5'b0_0100);
  assign rd_ok_o = (sig == 5'b1_0100);
endmodule

// File: rtl/epp_timeout_flag.sv
module epp_timeout_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_err_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq
  import epp_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = HOST_W / BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_xfer_i,
  input  logic              start_imm_i,
  input  logic              we_i,
  input  logic              addr_cyc_i,
  input  logic [IDX_W-1:0]  last_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  logic [HOST_W-1:0] imm_rdata_i,
  input  logic [HOST_W-1:0] mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [HOST_W-1:0] rdata_o,
  output logic              err_o,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic              per_addr_o,
  output logic [BYTE_W-1:0] per_wdata_o,
  input  logic [BYTE_W-1:0] per_rdata_i,
  input  logic              per_done_i,
  input  logic              per_err_i
);
  epp_state_e        state_q;
  logic [IDX_W-1:0]  idx_q, last_q;
  logic              we_q, addr_q;
  logic [HOST_W-1:0] wdata_q, rdata_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '1;
      mask_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_xfer_i) begin
            state_q <= ST_XFER;
            idx_q   <= '0;
            last_q  <= last_i;
            we_q    <= we_i;
            addr_q  <= addr_cyc_i;
            wdata_q <= wdata_i;
            rdata_q <= '1;
            mask_q  <= mask_i;
          end else if (start_imm_i) begin
            state_q <= ST_DONE;
            rdata_q <= imm_rdata_i;
            mask_q  <= mask_i;
          end
        end
        ST_XFER: begin
          if (per_err_i) begin
            state_q <= ST_DONE;
          end else if (per_done_i) begin
            if (!we_q) rdata_q[idx_q*BYTE_W +: BYTE_W] <= per_rdata_i;
            if (idx_q == last_q) state_q <= ST_DONE;
            else                 idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign rdata_o     = rdata_q & mask_q;
  assign per_req_o   = (state_q == ST_XFER);
  assign per_we_o    = we_q;
  assign per_addr_o  = addr_q;
  assign per_wdata_o = wdata_q[idx_q*BYTE_W +: BYTE_W];
  assign err_o       = per_req_o && per_err_i;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && !per_done_i && !per_err_i |=>
      per_req_o && $stable(per_wdata_o) && $stable(per_we_o) && $stable(per_addr_o));
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_err_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_req_o && per_err_i |=> !per_req_o && done_o);
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int HOST_W = 32,
  parameter int BYTE_W = 8,
  localparam int NBYTES = HOST_W / BYTE_W,
  localparam int IDX_W  = $clog2(NBYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [2:0]        host_off_i,
  input  logic [1:0]        host_size_i,
  input  logic [HOST_W-1:0] host_wdata_i,
  output logic              host_busy_o,
  output logic              host_done_o,
  output logic [HOST_W-1:0] host_rdata_o,
  input  logic [BYTE_W-1:0] ctrl_i,
  input  logic [BYTE_W-1:0] sts_pin_i,
  output logic [BYTE_W-1:0] sts_o,
  output logic              per_req_o,
  output logic              per_we_o,
  output logic              per_addr_o,
  output logic [BYTE_W-1:0] per_wdata_o,
  input  logic [BYTE_W-1:0] per_rdata_i,
  input  logic              per_done_i,
  input  logic              per_err_i
);
  logic wr_ok, rd_ok, gate_ok;
  logic acc, is_addr, is_data, is_sts;
  logic start_xfer, start_imm, clr, err, flag;
  logic [IDX_W-1:0]  last;
  logic [HOST_W-1:0] mask, imm_rdata;

  epp_mode_gate #(.CTRL_W(BYTE_W)) u_gate (
    .ctrl_i  (ctrl_i),
    .wr_ok_o (wr_ok),
    .rd_ok_o (rd_ok)
  );

  assign acc     = host_req_i && !host_busy_o;
  assign is_addr = (host_off_i == OFF_ADDR);
  assign is_data = (host_off_i == OFF_DATA);
  assign is_sts  = (host_off_i == OFF_STS);
  assign gate_ok = host_we_i ? wr_ok : rd_ok;

  assign start_xfer = acc && (is_addr || is_data) && gate_ok;
  assign start_imm  = acc && !start_xfer;
  assign clr        = acc && is_sts && host_we_i && host_wdata_i[STS_TMO];

  always_comb begin
    if (is_addr)                last = '0;
    else if (host_size_i == 2'd0) last = '0;
    else if (host_size_i == 2'd1) last = IDX_W'(1);
    else                        last = IDX_W'(NBYTES - 1);
  end

  // access-width mask for the read result
  always_comb begin
    for (int j = 0; j < NBYTES; j++)
      mask[j*BYTE_W +: BYTE_W] = (j <= int'(last)) ? {BYTE_W{1'b1}} : {BYTE_W{1'b0}};
  end

  assign sts_o     = {sts_pin_i[BYTE_W-1:1], flag};
  assign imm_rdata = (is_sts && !host_we_i) ? {{(HOST_W-BYTE_W){1'b0}}, sts_o} : '1;

  epp_byte_seq #(.HOST_W(HOST_W), .BYTE_W(BYTE_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_xfer_i (start_xfer),
    .start_imm_i  (start_imm),
    .we_i         (host_we_i),
    .addr_cyc_i   (is_addr),
    .last_i       (last),
    .wdata_i      (host_wdata_i),
    .imm_rdata_i  (imm_rdata),
    .mask_i       (mask),
    .busy_o       (host_busy_o),
    .done_o       (host_done_o),
    .rdata_o      (host_rdata_o),
    .err_o        (err),
    .per_req_o    (per_req_o),
    .per_we_o     (per_we_o),
    .per_addr_o   (per_addr_o),
    .per_wdata_o  (per_wdata_o),
    .per_rdata_i  (per_rdata_i),
    .per_done_i   (per_done_i),
    .per_err_i    (per_err_i)
  );

  epp_timeout_flag u_tmo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (err),
    .clr_i  (clr),
    .flag_o (flag)
  );

  assert_wr_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_busy_o && host_we_i && (is_addr || is_data) && !wr_ok
      |=> !per_req_o && host_done_o);
  assert_rd_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_busy_o && !host_we_i && (is_addr || is_data) && !rd_ok
      |=> !per_req_o && host_done_o);
  assert_other_off_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_i && !host_busy_o && !is_addr && !is_data |=> !per_req_o);
endmodule

// File: tb/tb_epp_cycle_ctrl.sv
module tb_epp_cycle_ctrl;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        host_req_i = 0, host_we_i = 0;
  logic [2:0]  host_off_i = 0;
  logic [1:0]  host_size_i = 0;
  logic [31:0] host_wdata_i = 0;
  logic        host_busy_o, host_done_o;
  logic [31:0] host_rdata_o;
  logic [7:0]  ctrl_i = 8'h0C, sts_pin_i = 8'h5A, sts_o;
  logic        per_req_o, per_we_o, per_addr_o;
  logic [7:0]  per_wdata_o, per_rdata_i = 0;
  logic        per_done_i = 0, per_err_i = 0;

  always #10 clk_i = ~clk_i;

  epp_cycle_ctrl dut (.*);

  int errors = 0, checks = 0;
  logic [9:0]  exp_q[$];
  string       cur_req = "R1";
  logic [31:0] rd_word = 0;
  int          err_at = -1, byte_n = 0;
  bit          pending = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor and responder for the peripheral side
  initial begin
    forever begin
      @(negedge clk_i);
      per_done_i = 0; per_err_i = 0;
      if (pending) begin
        if (byte_n == err_at) per_err_i = 1; else per_done_i = 1;
        per_rdata_i = rd_word[byte_n*8 +: 8];
        byte_n++;
        pending = 0;
      end else if (per_req_o) begin
        if (exp_q.size() == 0) begin
          chk(0, {cur_req, " unexpected peripheral cycle"},
              {22'b0, per_we_o, per_addr_o, per_wdata_o}, 32'h0);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          chk((per_we_o == e[9]) && (per_addr_o == e[8]) && (!e[9] || per_wdata_o == e[7:0]),
              {cur_req, " peripheral byte"}, {22'b0, per_we_o, per_addr_o, per_wdata_o},
              {22'b0, e});
        end
        pending = 1;
      end
    end
  end

  task automatic acc(input bit we, input logic [2:0] off, input logic [1:0] sz,
                     input logic [31:0] wd, input int n_exp, input logic [31:0] rdw,
                     input int erra, input bit chk_rd, input logic [31:0] exp_rd,
                     input string rq);
    int guard;
    cur_req = rq;
    rd_word = rdw; err_at = erra; byte_n = 0;
    for (int i = 0; i < n_exp; i++)
      exp_q.push_back({we, (off == 3'd3), wd[i*8 +: 8]});
    host_we_i = we; host_off_i = off; host_size_i = sz; host_wdata_i = wd;
    host_req_i = 1;
    @(negedge clk_i);
    host_req_i = 0;
    guard = 0;
    while (!host_done_o && guard < 200) begin
      @(negedge clk_i);
      guard++;
    end
    chk(host_done_o, {rq, " completion"}, {31'b0, host_done_o}, 32'h1);
    if (chk_rd) chk(host_rdata_o == exp_rd, {rq, " read data"}, host_rdata_o, exp_rd);
    @(negedge clk_i);
    chk(!host_done_o, "R11 done pulse width", {31'b0, host_done_o}, 32'h0);
    chk(exp_q.size() == 0, {rq, " missing peripheral cycles"}, exp_q.size(), 32'h0);
    exp_q.delete();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected<100000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(sts_o[0] == 0, "R1 timeout flag", {31'b0, sts_o[0]}, 32'h0);
    chk(!host_busy_o && !per_req_o, "R1 idle", {30'b0, host_busy_o, per_req_o}, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2/R4 address write, size code ignored
    ctrl_i = 8'h04;
    acc(1, 3'd3, 2'd2, 32'h1234_56A5, 1, 0, -1, 0, 0, "R4 address write one byte");
    // R5 wide writes
    acc(1, 3'd4, 2'd2, 32'h1122_3344, 4, 0, -1, 0, 0, "R5 four byte write order");
    acc(1, 3'd4, 2'd1, 32'h0000_BEEF, 2, 0, -1, 0, 0, "R5 two byte write order");
    acc(1, 3'd4, 2'd0, 32'h0000_0077, 1, 0, -1, 0, 0, "R4 one byte data write");
    // R2 blocked write: select set
    ctrl_i = 8'h0C;
    acc(1, 3'd4, 2'd2, 32'hDEAD_BEEF, 0, 0, -1, 0, 0, "R2 blocked write select");
    chk(sts_o[0] == 0, "R2 blocked write flag unchanged", {31'b0, sts_o[0]}, 32'h0);
    // R12 don't-care bits
    ctrl_i = 8'hD4;
    acc(1, 3'd4, 2'd1, 32'h0000_C3D2, 2, 0, -1, 0, 0, "R12 write with bits 7,6,4 set");
    ctrl_i = 8'hF4;
    acc(0, 3'd4, 2'd0, 0, 1, 32'h0000_0066, -1, 1, 32'h66, "R12 read with bits 7,6,4 set");
    // R6 reads
    ctrl_i = 8'h24;
    acc(0, 3'd3, 2'd0, 0, 1, 32'h0000_005A, -1, 1, 32'h5A, "R6 address read");
    acc(0, 3'd4, 2'd2, 0, 4, 32'h0403_0201, -1, 1, 32'h0403_0201, "R6 four byte read");
    acc(0, 3'd4, 2'd1, 0, 2, 32'h0000_CDAB, -1, 1, 32'h0000_CDAB, "R6 two byte read");
    acc(0, 3'd4, 2'd3, 0, 4, 32'h8877_6655, -1, 1, 32'h8877_6655, "R4 size code 3 is four bytes");
    // R2 write blocked in read mode
    acc(1, 3'd4, 2'd0, 32'h0000_0099, 0, 0, -1, 0, 0, "R2 blocked write direction");
    // R3 blocked reads in write mode
    ctrl_i = 8'h04;
    acc(0, 3'd4, 2'd2, 0, 0, 0, -1, 1, 32'hFFFF_FFFF, "R3 blocked four byte read");
    acc(0, 3'd4, 2'd1, 0, 0, 0, -1, 1, 32'h0000_FFFF, "R3 blocked two byte read");
    ctrl_i = 8'h25;
    acc(0, 3'd3, 2'd0, 0, 0, 0, -1, 1, 32'h0000_00FF, "R3 blocked address read strobe");
    // R13 other offsets
    ctrl_i = 8'h04;
    acc(1, 3'd0, 2'd0, 32'h0000_0011, 0, 0, -1, 0, 0, "R13 offset 0 write");
    acc(0, 3'd2, 2'd1, 0, 0, 0, -1, 1, 32'h0000_FFFF, "R13 offset 2 read");
    // R10 error on third byte of a read
    ctrl_i = 8'h24;
    acc(0, 3'd4, 2'd2, 0, 3, 32'hA4A3_A2A1, 2, 1, 32'hFFFF_A2A1, "R10 early stop fill");
    chk(sts_o[0] == 1, "R7 flag after read error", {31'b0, sts_o[0]}, 32'h1);
    // R9 status read shows flag in bit 0
    sts_pin_i = 8'h5A;
    acc(0, 3'd1, 2'd0, 0, 0, 0, -1, 1, 32'h5B, "R9 status read with flag");
    // R8 write without bit 0 keeps flag
    acc(1, 3'd1, 2'd0, 32'h0000_00FE, 0, 0, -1, 0, 0, "R8 status write bit0 clear");
    acc(0, 3'd1, 2'd0, 0, 0, 0, -1, 1, 32'h5B, "R8 flag kept");
    // R7 sticky through good transfer
    acc(0, 3'd4, 2'd0, 0, 1, 32'h0000_0042, -1, 1, 32'h42, "R7 good read after error");
    chk(sts_o[0] == 1, "R7 flag sticky", {31'b0, sts_o[0]}, 32'h1);
    // R8 clear
    acc(1, 3'd1, 2'd0, 32'h0000_0001, 0, 0, -1, 0, 0, "R8 status write bit0 set");
    chk(sts_o[0] == 0, "R8 flag cleared", {31'b0, sts_o[0]}, 32'h0);
    sts_pin_i = 8'h81;
    acc(0, 3'd1, 2'd0, 0, 0, 0, -1, 1, 32'h80, "R9 pin bit0 replaced");
    // R7/R10 error on first byte of a wide write
    ctrl_i = 8'h04;
    acc(1, 3'd4, 2'd2, 32'hCAFE_F00D, 1, 0, 0, 0, 0, "R10 write stops on first byte");
    chk(sts_o[0] == 1, "R7 flag after write error", {31'b0, sts_o[0]}, 32'h1);
    // R7 address cycle error
    acc(1, 3'd1, 2'd0, 32'h0000_0001, 0, 0, -1, 0, 0, "R8 clear again");
    acc(1, 3'd3, 2'd0, 32'h0000_003C, 1, 0, 0, 0, 0, "R7 address cycle error");
    chk(sts_o[0] == 1, "R7 flag after address error", {31'b0, sts_o[0]}, 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule